// File: doc/BRIEF.md
# Pass Voltage Tuning Controller

This block finds, for each flash block, the lowest pass-through voltage code at which reads still stay within the error-correction budget. It also keeps that code in a per-block table. A scheduler starts a tuning run with a start strobe and a block index, typically once per block per day. The controller then probes the block's worst-case page at a series of trial codes. Each probe goes out as a read request carrying the code, and each one waits for a single-cycle error-count strobe from the ECC decoder.

The search has two phases. First the controller reads at the nominal code to learn how much correction capability is still spare. It then walks the code down in coarse steps until a probe's error count goes above the correction limit. Finally it climbs back up in fine steps until the count fits again, and it writes that code into the table. If the nominal read already uses the whole budget, the controller stores nominal and does no search.

Normal reads get their code from a lookup port. When a normal read turns out uncorrectable, the host reports it on the failure port. The controller then retries that page with the stored code raised one fine step at a time. A successful retry writes the raised code back to the table. If the code reaches nominal and the read still fails, the controller flags the read as uncorrectable.

Top module: `vpass_tuner`

## Requirements
- R1: A lookup of a block that has never been tuned or retried returns the nominal code 200, with `lk_valid` high, one cycle after `lk_req`.
- R2: A tuning run first probes at code 200. Every probe of the run carries the started block index and the worst-case page stored for that block through the page-write port (page 0 if none was written).
- R3: If the error count at nominal is at or above the correction limit (`ECC_LIMIT`, 40 here), the run finishes with `done_code` 200 and issues no further probe.
- R4: In the coarse phase, each probe is 4 codes below the previous one, and no probe ever goes below the floor code 188 (nominal minus 6 percent).
- R5: When a coarse probe returns more errors than the limit, the fine phase probes the failing code plus 1, then goes up by 1 per probe. It commits the first code whose count is at or below the limit. A count equal to the limit fits.
- R6: If every coarse probe fits, down to and including 188, the run commits 188.
- R7: After a tuning run, lookups of that block return the committed code.
- R8: On a read failure, the retry probes the failing page at the stored code plus 1, then goes up by 1 per failed attempt. The first fitting code is reported on `done` and written back to the table.
- R9: A retry that fails at code 200, or that starts from a stored code of 200, raises `done_uncorr` with `done_code` 200. The table keeps its previous value in that case.
- R10: While `busy` is high, `tune_start` and `fail_req` are ignored: no probe and no table change follows from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tune_start | input | 1 | Start a tuning run (taken only when idle) |
| tune_blk | input | BLK_W | Block to tune |
| fail_req | input | 1 | A normal read was uncorrectable; start a retry |
| fail_blk | input | BLK_W | Block of the failed read |
| fail_page | input | PAGE_W | Page of the failed read |
| ecc_valid | input | 1 | One-cycle strobe: error count of the last probe |
| ecc_errs | input | ERR_W | Error count reported by the decoder |
| probe_req | output | 1 | One-cycle probe read request |
| probe_blk | output | BLK_W | Block of the probe |
| probe_page | output | PAGE_W | Page of the probe |
| probe_code | output | CODE_W | Pass voltage code for the probe |
| lk_req | input | 1 | Lookup of a block's stored code |
| lk_blk | input | BLK_W | Block to look up |
| lk_valid | output | 1 | Lookup result valid |
| lk_code | output | CODE_W | Stored code (nominal if untouched) |
| pg_we | input | 1 | Write a block's worst-case page |
| pg_blk | input | BLK_W | Block for the page write |
| pg_page | input | PAGE_W | Worst-case page index |
| done | output | 1 | One-cycle end of a tuning run or retry |
| done_code | output | CODE_W | Committed or final code |
| done_uncorr | output | 1 | Retry ran out of headroom (with `done`) |
| busy | output | 1 | A run or retry is in progress |

## Verification
The bench builds the block with 16 table entries, nominal 200, a 6 percent floor (188), coarse and fine steps of 4 and 1, and a correction limit of 40. With these values a full coarse descent takes three probes below nominal, and a fine ascent or a retry climb of a few codes ends well inside the run. This brings the floor clamp, the limit-equal boundary, the zero-spare shortcut, the climb to nominal and the uncorrectable outcome all within a short run. The bench's decoder model makes errors depend on the probed code through a knee code, so each scenario picks a knee and checks the exact probe sequence and the committed code.

// File: rtl/vpass_pkg.sv
package vpass_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_BASE,
    ST_COARSE,
    ST_FINE,
    ST_COMMIT,
    ST_RETRY
  } vp_state_e;
endpackage

// File: rtl/vpass_table.sv
module vpass_table #(
  parameter int NBLK   = 64,
  parameter int BLK_W  = 6,
  parameter int CODE_W = 8,
  parameter int PAGE_W = 8,
  parameter int NOM    = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BLK_W-1:0]  waddr,
  input  logic [CODE_W-1:0] wcode,
  input  logic [BLK_W-1:0]  raddr_a,
  output logic [CODE_W-1:0] code_a,
  output logic [PAGE_W-1:0] page_a,
  input  logic [BLK_W-1:0]  raddr_b,
  output logic [CODE_W-1:0] code_b,
  input  logic              pg_we,
  input  logic [BLK_W-1:0]  pg_addr,
  input  logic [PAGE_W-1:0] pg_data
);
  localparam logic [CODE_W-1:0] NOM_C = CODE_W'(NOM);

  logic [CODE_W-1:0] code_mem [NBLK];
  logic [PAGE_W-1:0] page_mem [NBLK];
  logic [NBLK-1:0]   code_set_q, page_set_q;
  logic [CODE_W-1:0] ca_q, cb_q;
  logic [PAGE_W-1:0] pa_q;
  logic              va_q, vb_q, vp_q;

  // RAM-style storage: no reset, registered reads
  always_ff @(posedge clk) begin
    if (we)    code_mem[waddr]   <= wcode;
    if (pg_we) page_mem[pg_addr] <= pg_data;
    ca_q <= code_mem[raddr_a];
    cb_q <= code_mem[raddr_b];
    pa_q <= page_mem[raddr_a];
  end

  // Written-entry flags give the reset defaults
  always_ff @(posedge clk) begin
    if (rst) begin
      code_set_q <= '0;
      page_set_q <= '0;
      va_q <= 1'b0;
      vb_q <= 1'b0;
      vp_q <= 1'b0;
    end else begin
      if (we)    code_set_q[waddr]   <= 1'b1;
      if (pg_we) page_set_q[pg_addr] <= 1'b1;
      va_q <= code_set_q[raddr_a];
      vb_q <= code_set_q[raddr_b];
      vp_q <= page_set_q[raddr_a];
    end
  end

  assign code_a = va_q ? ca_q : NOM_C;
  assign code_b = vb_q ? cb_q : NOM_C;
  assign page_a = vp_q ? pa_q : '0;
endmodule

// File: rtl/vpass_fsm.sv
module vpass_fsm
  import vpass_pkg::*;
#(
  parameter int BLK_W     = 6,
  parameter int PAGE_W    = 8,
  parameter int CODE_W    = 8,
  parameter int ERR_W     = 8,
  parameter int NOM       = 200,
  parameter int FLOOR     = 188,
  parameter int COARSE    = 4,
  parameter int FINE      = 1,
  parameter int ECC_LIMIT = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tune_start,
  input  logic [BLK_W-1:0]  tune_blk,
  input  logic              fail_req,
  input  logic [BLK_W-1:0]  fail_blk,
  input  logic [PAGE_W-1:0] fail_page,
  input  logic              ecc_valid,
  input  logic [ERR_W-1:0]  ecc_errs,
  output logic [BLK_W-1:0]  tbl_raddr,
  input  logic [CODE_W-1:0] tbl_code,
  input  logic [PAGE_W-1:0] tbl_page,
  output logic              tbl_we,
  output logic [BLK_W-1:0]  tbl_waddr,
  output logic [CODE_W-1:0] tbl_wcode,
  output logic              probe_req,
  output logic [BLK_W-1:0]  probe_blk,
  output logic [PAGE_W-1:0] probe_page,
  output logic [CODE_W-1:0] probe_code,
  output logic              done,
  output logic [CODE_W-1:0] done_code,
  output logic              done_uncorr,
  output logic              busy
);
  localparam logic [CODE_W-1:0] NOM_C    = CODE_W'(NOM);
  localparam logic [CODE_W-1:0] FLOOR_C  = CODE_W'(FLOOR);
  localparam logic [CODE_W-1:0] COARSE_C = CODE_W'(COARSE);
  localparam logic [CODE_W-1:0] FINE_C   = CODE_W'(FINE);
  localparam logic [ERR_W-1:0]  LIM_C    = ERR_W'(ECC_LIMIT);

  vp_state_e         state_q;
  logic [BLK_W-1:0]  blk_q;
  logic [PAGE_W-1:0] page_q;
  logic [CODE_W-1:0] code_q;
  logic              retry_q, probe_q, done_q, unc_q;

  logic              fit;
  logic [CODE_W-1:0] coarse_nxt, fine_nxt, retry_first;

  assign fit         = (ecc_errs <= LIM_C);
  assign coarse_nxt  = (code_q >= FLOOR_C + COARSE_C) ? code_q - COARSE_C : FLOOR_C;
  assign fine_nxt    = (code_q >= NOM_C - FINE_C) ? NOM_C : code_q + FINE_C;
  assign retry_first = (tbl_code >= NOM_C - FINE_C) ? NOM_C : tbl_code + FINE_C;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      blk_q   <= '0;
      page_q  <= '0;
      code_q  <= NOM_C;
      retry_q <= 1'b0;
      probe_q <= 1'b0;
      done_q  <= 1'b0;
      unc_q   <= 1'b0;
    end else begin
      probe_q <= 1'b0;
      done_q  <= 1'b0;
      unc_q   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (tune_start) begin
            blk_q   <= tune_blk;
            retry_q <= 1'b0;
            state_q <= ST_FETCH;
          end else if (fail_req) begin
            blk_q   <= fail_blk;
            page_q  <= fail_page;
            retry_q <= 1'b1;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (!retry_q) begin
            code_q  <= NOM_C;
            page_q  <= tbl_page;
            probe_q <= 1'b1;
            state_q <= ST_BASE;
          end else if (tbl_code >= NOM_C) begin
            code_q  <= NOM_C;
            done_q  <= 1'b1;
            unc_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            code_q  <= retry_first;
            probe_q <= 1'b1;
            state_q <= ST_RETRY;
          end
        end
        ST_BASE: begin
          if (ecc_valid) begin
            if (ecc_errs >= LIM_C) begin
              state_q <= ST_COMMIT;
            end else begin
              code_q  <= coarse_nxt;
              probe_q <= 1'b1;
              state_q <= ST_COARSE;
            end
          end
        end
        ST_COARSE: begin
          if (ecc_valid) begin
            if (!fit) begin
              code_q  <= fine_nxt;
              probe_q <= 1'b1;
              state_q <= ST_FINE;
            end else if (code_q == FLOOR_C) begin
              state_q <= ST_COMMIT;
            end else begin
              code_q  <= coarse_nxt;
              probe_q <= 1'b1;
            end
          end
        end
        ST_FINE: begin
          if (ecc_valid) begin
            if (fit || code_q == NOM_C) begin
              state_q <= ST_COMMIT;
            end else begin
              code_q  <= fine_nxt;
              probe_q <= 1'b1;
            end
          end
        end
        ST_COMMIT: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_RETRY: begin
          if (ecc_valid) begin
            if (fit) begin
              state_q <= ST_COMMIT;
            end else if (code_q == NOM_C) begin
              done_q  <= 1'b1;
              unc_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              code_q  <= fine_nxt;
              probe_q <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tbl_raddr   = (state_q == ST_IDLE) ? (tune_start ? tune_blk : fail_blk) : blk_q;
  assign tbl_we      = (state_q == ST_COMMIT);
  assign tbl_waddr   = blk_q;
  assign tbl_wcode   = code_q;
  assign probe_req   = probe_q;
  assign probe_blk   = blk_q;
  assign probe_page  = page_q;
  assign probe_code  = code_q;
  assign done        = done_q;
  assign done_code   = code_q;
  assign done_uncorr = unc_q;
  assign busy        = (state_q != ST_IDLE);

  // R4
  probe_range_chk: assert property (@(posedge clk) disable iff (rst)
    probe_req |-> (probe_code >= FLOOR_C && probe_code <= NOM_C));

  // R5
  fine_step_chk: assert property (@(posedge clk) disable iff (rst)
    (probe_q && state_q == ST_FINE && $past(state_q) == ST_FINE)
      |-> code_q == $past(code_q) + FINE_C);

  // R8
  retry_step_chk: assert property (@(posedge clk) disable iff (rst)
    (probe_q && state_q == ST_RETRY && $past(state_q) == ST_RETRY)
      |-> code_q == $past(code_q) + FINE_C);

  // R9
  uncorr_nom_chk: assert property (@(posedge clk) disable iff (rst)
    done_uncorr |-> (done && done_code == NOM_C));

  // R6
  commit_range_chk: assert property (@(posedge clk) disable iff (rst)
    tbl_we |-> (tbl_wcode >= FLOOR_C && tbl_wcode <= NOM_C));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/vpass_tuner.sv
module vpass_tuner #(
  parameter int NBLK      = 64,
  parameter int PAGE_W    = 8,
  parameter int CODE_W    = 8,
  parameter int ERR_W     = 8,
  parameter int NOM       = 200,
  parameter int FLOOR_PCT = 6,
  parameter int COARSE    = 4,
  parameter int FINE      = 1,
  parameter int ECC_LIMIT = 40,
  localparam int BLK_W    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tune_start,
  input  logic [BLK_W-1:0]  tune_blk,
  input  logic              fail_req,
  input  logic [BLK_W-1:0]  fail_blk,
  input  logic [PAGE_W-1:0] fail_page,
  input  logic              ecc_valid,
  input  logic [ERR_W-1:0]  ecc_errs,
  output logic              probe_req,
  output logic [BLK_W-1:0]  probe_blk,
  output logic [PAGE_W-1:0] probe_page,
  output logic [CODE_W-1:0] probe_code,
  input  logic              lk_req,
  input  logic [BLK_W-1:0]  lk_blk,
  output logic              lk_valid,
  output logic [CODE_W-1:0] lk_code,
  input  logic              pg_we,
  input  logic [BLK_W-1:0]  pg_blk,
  input  logic [PAGE_W-1:0] pg_page,
  output logic              done,
  output logic [CODE_W-1:0] done_code,
  output logic              done_uncorr,
  output logic              busy
);
  localparam int FLOOR = NOM - (NOM * FLOOR_PCT) / 100;

  logic [BLK_W-1:0]  tbl_raddr, tbl_waddr;
  logic [CODE_W-1:0] tbl_code, tbl_wcode;
  logic [PAGE_W-1:0] tbl_page;
  logic              tbl_we;
  logic              lk_valid_q;

  vpass_table #(
    .NBLK(NBLK), .BLK_W(BLK_W), .CODE_W(CODE_W), .PAGE_W(PAGE_W), .NOM(NOM)
  ) u_table (
    .clk(clk), .rst(rst),
    .we(tbl_we), .waddr(tbl_waddr), .wcode(tbl_wcode),
    .raddr_a(tbl_raddr), .code_a(tbl_code), .page_a(tbl_page),
    .raddr_b(lk_blk), .code_b(lk_code),
    .pg_we(pg_we), .pg_addr(pg_blk), .pg_data(pg_page)
  );

  vpass_fsm #(
    .BLK_W(BLK_W), .PAGE_W(PAGE_W), .CODE_W(CODE_W), .ERR_W(ERR_W),
    .NOM(NOM), .FLOOR(FLOOR), .COARSE(COARSE), .FINE(FINE), .ECC_LIMIT(ECC_LIMIT)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .tune_start(tune_start), .tune_blk(tune_blk),
    .fail_req(fail_req), .fail_blk(fail_blk), .fail_page(fail_page),
    .ecc_valid(ecc_valid), .ecc_errs(ecc_errs),
    .tbl_raddr(tbl_raddr), .tbl_code(tbl_code), .tbl_page(tbl_page),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wcode(tbl_wcode),
    .probe_req(probe_req), .probe_blk(probe_blk), .probe_page(probe_page),
    .probe_code(probe_code),
    .done(done), .done_code(done_code), .done_uncorr(done_uncorr), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) lk_valid_q <= 1'b0;
    else     lk_valid_q <= lk_req;
  end
  assign lk_valid = lk_valid_q;

  // R1
  lk_latency_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_valid);
endmodule

// File: tb/vpass_tuner_bench.sv
module vpass_tuner_bench;
  localparam int NBLK = 16;
  localparam int BW = 4;
  localparam int NOMV = 200;
  localparam int FLR = 188;
  localparam int LIM = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tune_start = 0, fail_req = 0, ecc_valid = 0, lk_req = 0, pg_we = 0;
  logic [BW-1:0] tune_blk = '0, fail_blk = '0, lk_blk = '0, pg_blk = '0;
  logic [7:0] fail_page = '0, pg_page = '0, ecc_errs = '0;
  logic probe_req, lk_valid, done, done_uncorr, busy;
  logic [BW-1:0] probe_blk;
  logic [7:0] probe_page, probe_code, lk_code, done_code;

  always #2 clk = ~clk;

  vpass_tuner #(.NBLK(NBLK), .ECC_LIMIT(LIM)) u_vpass_tuner (
    .clk(clk), .rst(rst), .tune_start(tune_start), .tune_blk(tune_blk),
    .fail_req(fail_req), .fail_blk(fail_blk), .fail_page(fail_page),
    .ecc_valid(ecc_valid), .ecc_errs(ecc_errs),
    .probe_req(probe_req), .probe_blk(probe_blk), .probe_page(probe_page),
    .probe_code(probe_code), .lk_req(lk_req), .lk_blk(lk_blk),
    .lk_valid(lk_valid), .lk_code(lk_code), .pg_we(pg_we), .pg_blk(pg_blk),
    .pg_page(pg_page), .done(done), .done_code(done_code),
    .done_uncorr(done_uncorr), .busy(busy)
  );

  int n_chk = 0, n_err = 0;
  int base_e = 10, knee = 0;
  int resp_cnt = 0, resp_code = 0;
  int cyc = 0;
  string cur_tag = "R2";
  int q_pblk[$], q_ppage[$], q_pcode[$];
  int q_dcode[$], q_dunc[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int err_of(input int c);
    if (c == NOMV) return base_e;
    return (c >= knee) ? LIM : LIM + 3;
  endfunction

  // Driver side: expected probe/result sequence for a tuning run
  task automatic exp_tune(input int b, input int p);
    int c;
    q_pblk.push_back(b); q_ppage.push_back(p); q_pcode.push_back(NOMV);
    if (base_e >= LIM) begin
      q_dcode.push_back(NOMV); q_dunc.push_back(0);
      return;
    end
    c = NOMV;
    forever begin
      c = (c - 4 > FLR) ? c - 4 : FLR;
      q_pblk.push_back(b); q_ppage.push_back(p); q_pcode.push_back(c);
      if (err_of(c) > LIM) begin
        forever begin
          c = c + 1;
          q_pblk.push_back(b); q_ppage.push_back(p); q_pcode.push_back(c);
          if (err_of(c) <= LIM || c == NOMV) break;
        end
        break;
      end
      if (c == FLR) break;
    end
    q_dcode.push_back(c); q_dunc.push_back(0);
  endtask

  task automatic exp_retry(input int b, input int p, input int stored);
    int c;
    if (stored >= NOMV) begin
      q_dcode.push_back(NOMV); q_dunc.push_back(1);
      return;
    end
    c = stored;
    forever begin
      c = c + 1;
      q_pblk.push_back(b); q_ppage.push_back(p); q_pcode.push_back(c);
      if (err_of(c) <= LIM) begin q_dcode.push_back(c); q_dunc.push_back(0); break; end
      if (c == NOMV) begin q_dcode.push_back(NOMV); q_dunc.push_back(1); break; end
    end
  endtask

  // Monitor and ECC responder
  always @(negedge clk) begin
    cyc++;
    ecc_valid = 1'b0;
    if (resp_cnt == 1) begin
      ecc_valid = 1'b1;
      ecc_errs = 8'(err_of(resp_code));
    end
    if (resp_cnt > 0) resp_cnt--;
    if (!rst && probe_req) begin
      if (q_pcode.size() == 0) begin
        check(0, {cur_tag, " unexpected probe"}, int'(probe_code), -1);
      end else begin
        int eb, ep, ec;
        eb = q_pblk.pop_front(); ep = q_ppage.pop_front(); ec = q_pcode.pop_front();
        check(int'(probe_code) == ec, {cur_tag, " probe code"}, int'(probe_code), ec);
        check(int'(probe_blk) == eb, {cur_tag, " probe block"}, int'(probe_blk), eb);
        check(int'(probe_page) == ep, {cur_tag, " probe page"}, int'(probe_page), ep);
      end
      resp_cnt = 3;
      resp_code = int'(probe_code);
    end
    if (!rst && done) begin
      if (q_dcode.size() == 0) begin
        check(0, {cur_tag, " unexpected done"}, int'(done_code), -1);
      end else begin
        int ed, eu;
        ed = q_dcode.pop_front(); eu = q_dunc.pop_front();
        check(int'(done_code) == ed, {cur_tag, " done code"}, int'(done_code), ed);
        check(int'(done_uncorr) == eu, {cur_tag, " uncorrectable flag"}, int'(done_uncorr), eu);
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(negedge clk) if (cyc > 100000) begin
    check(0, "watchdog", cyc, 100000);
    finish_run();
  end

  task automatic wait_quiet();
    @(negedge clk);
    while (busy || resp_cnt != 0 || q_pcode.size() != 0 || q_dcode.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_tune(input int b, input int p);
    exp_tune(b, p);
    tune_blk = BW'(b); tune_start = 1'b1;
    @(negedge clk);
    tune_start = 1'b0;
    wait_quiet();
  endtask

  task automatic do_retry(input int b, input int p, input int stored);
    exp_retry(b, p, stored);
    fail_blk = BW'(b); fail_page = 8'(p); fail_req = 1'b1;
    @(negedge clk);
    fail_req = 1'b0;
    wait_quiet();
  endtask

  task automatic lookup(input int b, input int exp, input string tag);
    lk_blk = BW'(b); lk_req = 1'b1;
    @(negedge clk);
    lk_req = 1'b0;
    check(lk_valid == 1'b1, {tag, " lookup valid"}, int'(lk_valid), 1);
    check(int'(lk_code) == exp, {tag, " lookup code"}, int'(lk_code), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !probe_req && !done, "reset idle", int'(busy), 0);

    // R1: untouched block reads nominal
    lookup(3, NOMV, "R1");

    // R2 R4 R5: page written, knee 190 → 200,196,192,188,189,190
    pg_blk = 4'd5; pg_page = 8'h2A; pg_we = 1'b1;
    @(negedge clk);
    pg_we = 1'b0;
    cur_tag = "R5"; base_e = 10; knee = 190;
    do_tune(5, 42);
    // R7
    lookup(5, 190, "R7");

    // R3: base over limit, then base exactly at limit
    cur_tag = "R3"; base_e = 45; knee = 0;
    do_tune(6, 0);
    base_e = LIM;
    do_tune(7, 0);
    lookup(7, NOMV, "R3");

    // R6: every coarse step fits → floor
    cur_tag = "R6"; base_e = 10; knee = 100;
    do_tune(8, 0);
    lookup(8, FLR, "R6");

    // R4 R5: first coarse step fails → fine from 197
    cur_tag = "R4"; base_e = 10; knee = 197;
    do_tune(9, 0);
    lookup(9, 197, "R4");

    // R8: retry from 190 with knee 192
    cur_tag = "R8"; knee = 192;
    do_retry(5, 77, 190);
    lookup(5, 192, "R8");

    // R9: stored nominal → immediate uncorrectable
    cur_tag = "R9";
    do_retry(6, 3, NOMV);
    // R9: climb 198..200 all failing, table unchanged
    knee = 250; base_e = LIM + 3;
    do_retry(9, 4, 197);
    lookup(9, 197, "R9");

    // R10: start and failure requests during a run are ignored
    cur_tag = "R10"; base_e = 10; knee = 100;
    exp_tune(10, 0);
    tune_blk = 4'd10; tune_start = 1'b1;
    @(negedge clk);
    tune_start = 1'b0;
    repeat (4) @(negedge clk);
    tune_blk = 4'd11; tune_start = 1'b1;
    fail_blk = 4'd12; fail_page = 8'd9; fail_req = 1'b1;
    @(negedge clk);
    tune_start = 1'b0; fail_req = 1'b0;
    wait_quiet();
    lookup(11, NOMV, "R10");
    lookup(12, NOMV, "R10");
    lookup(10, FLR, "R10");

    check(q_pcode.size() == 0 && q_dcode.size() == 0, "leftover expectations",
          q_pcode.size() + q_dcode.size(), 0);
    finish_run();
  end
endmodule